// File: doc/BRIEF.md
# Memory-Window to SPI Byte Bridge

This block sits between a CPU-side flash mapping window and a single shared SPI bus. Each access on the window is 1, 2, 3 or 4 bytes wide and carries an offset. The block maps that offset to one of several flash devices. The first device owns a 64 MiB segment at the bottom of the window. The next four devices each own 32 MiB, packed one after another above it. Any offset beyond the last segment belongs to no device.

Two per-device flag vectors come from the register file: one selects user mode and one grants write permission. When the addressed device is in user mode, each byte of the access becomes one full-duplex SPI byte exchange. The bytes are handled from the least significant lane upward. A read sends 0x00 on each exchange and packs each returned byte into its lane. A write sends the bytes of the write data. The SPI engine runs in mode 0, sends the MSB first, and uses a clock divider set by a parameter. Chip selects stay under register control and are not driven here, so software can chain several window accesses into one flash command.

Top module: `flash_win_spi_bridge`

## Requirements
- R1: While reset is asserted and right after it is released, `req_ready` is 0, `spi_sck` is 0 and `spi_mosi` is 0.
- R2: The window is split as follows. Offsets 0x0000000 to 0x3FFFFFF select device 0. Device k (k = 1 to 4) owns the 32 MiB that starts at 0x4000000 + (k-1)*0x2000000. The lowest and highest byte of each segment decode to that device.
- R3: A read of N bytes (`req_size` = N-1) to a user-mode device performs exactly N SPI byte exchanges. Each exchange sends 0x00. The byte received in exchange i lands in `rsp_rdata[8i+7:8i]`, and the lanes at and above N read as 0.
- R4: A write of N bytes to a user-mode device with write permission performs exactly N exchanges. Exchange i sends `req_wdata[8i+7:8i]`, in ascending order of i.
- R5: A write to a user-mode device whose `dev_wr_en` bit is 0 completes without any SCK edge.
- R6: A read of a device whose `dev_user_mode` bit is 0 returns 0xFFFFFFFF and causes no SCK edge.
- R7: A write to a device whose `dev_user_mode` bit is 0 completes without any SCK edge, whatever its write permission.
- R8: An access at or above offset 0xC000000 returns 0 on a read, is dropped on a write, and causes no SCK edge.
- R9: `req_ready` is a single-cycle pulse. It arrives 16*SCK_HALF*N+1 cycles after the request is first presented for an access with N exchanges, and 1 cycle after it for an access with no exchanges. SCK is low while `req_ready` is high.
- R10: Each SPI byte is sent MSB first in mode 0. SCK idles low. Each high phase lasts exactly SCK_HALF clock cycles, and MOSI does not change while SCK is high.
- R11: The mode and write-enable flags are used only for the addressed device. An access to a user-mode device works when every other device's flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the mapping window |
| req_size | input | $clog2(DATA_W/8) | Access size in bytes minus one |
| req_wdata | input | DATA_W | Write data, lane 0 first |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid while `req_ready` is high |
| dev_user_mode | input | NUM_DEV | Per-device user-mode flag |
| dev_wr_en | input | NUM_DEV | Per-device write permission |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |

## Verification
Three internal faults show up at the ports within one access. A wrong sequencer state or byte index sends too few or too many bytes or puts returned bytes in the wrong lanes. This is visible when `req_ready` comes back, and the ready latency moves by a multiple of 16*SCK_HALF cycles. A wrong segment decode makes a boundary access go silent or return 0 or all ones when it should exchange data. A wrong divider count or shift order changes a high-phase length or the MSB-first byte image on MOSI during the first exchange.

// File: rtl/fwsb_pkg.sv
package fwsb_pkg;

    // Sequencer states of the bridge
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_RESP  = 2'd2
    } seq_state_e;

    // Bit offset of a byte lane inside a data word
    function automatic int unsigned lane_lsb(input int unsigned lane);
        return lane * 8;
    endfunction

endpackage

// File: rtl/fwsb_seg_decode.sv
module fwsb_seg_decode #(
    parameter int ADDR_W    = 28,
    parameter int NUM_DEV   = 5,
    parameter int SEG0_LOG2 = 26,
    parameter int SEGN_LOG2 = 25,
    localparam int DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [DEV_W-1:0]  dev_idx
);
    localparam int AW1 = ADDR_W + 1;

    logic [NUM_DEV-1:0] match;
    logic [AW1-1:0]     addr_x;

    assign addr_x = {1'b0, addr};

    // One range comparator per device segment; a wrapped difference is
    // always larger than the segment span, so one compare covers both ends.
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_seg
        localparam logic [AW1-1:0] UNIT = AW1'(1);
        localparam logic [AW1-1:0] BASE = (g == 0) ? '0 :
            ((UNIT << SEG0_LOG2) + (AW1'(g - 1) << SEGN_LOG2));
        localparam logic [AW1-1:0] SPAN = (g == 0) ?
            (UNIT << SEG0_LOG2) : (UNIT << SEGN_LOG2);
        logic [AW1-1:0] rel;
        assign rel      = addr_x - BASE;
        assign match[g] = (rel < SPAN);
    end

    always_comb begin
        dev_idx = '0;
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (match[i]) begin
                dev_idx = DEV_W'(i);
            end
        end
    end

    assign hit = |match;

endmodule

// File: rtl/fwsb_spi_shift.sv
module fwsb_spi_shift #(
    parameter int SCK_HALF = 2,
    localparam int CNT_W   = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    typedef struct packed {
        logic             busy;
        logic             sck;
        logic [2:0]       bit_n;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       tx;
        logic [7:0]       rx;
    } sh_t;

    sh_t  sh_d, sh_q;
    logic tick;

    assign tick = (sh_q.cnt == CNT_W'(SCK_HALF - 1));

    always_comb begin
        sh_d = sh_q;
        done = 1'b0;
        if (sh_q.busy) begin
            sh_d.cnt = tick ? '0 : sh_q.cnt + 1'b1;
        end
        if (sh_q.busy && tick) begin
            if (!sh_q.sck) begin
                // rising edge: sample the slave
                sh_d.sck = 1'b1;
                sh_d.rx  = {sh_q.rx[6:0], spi_miso};
            end else begin
                // falling edge: advance to the next bit or finish
                sh_d.sck = 1'b0;
                if (sh_q.bit_n == 3'd7) begin
                    sh_d.busy = 1'b0;
                    done      = 1'b1;
                end else begin
                    sh_d.bit_n = sh_q.bit_n + 3'd1;
                    sh_d.tx    = {sh_q.tx[6:0], 1'b0};
                end
            end
        end
        if (start) begin
            sh_d.busy  = 1'b1;
            sh_d.sck   = 1'b0;
            sh_d.cnt   = '0;
            sh_d.bit_n = '0;
            sh_d.tx    = tx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign spi_sck  = sh_q.sck;
    assign spi_mosi = sh_q.tx[7];
    assign rx_byte  = sh_q.rx;

endmodule

// File: rtl/flash_win_spi_bridge.sv
module flash_win_spi_bridge
    import fwsb_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int NUM_DEV   = 5,
    parameter int SEG0_LOG2 = 26,
    parameter int SEGN_LOG2 = 25,
    parameter int DATA_W    = 32,
    parameter int SCK_HALF  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [$clog2(DATA_W/8)-1:0]   req_size,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          req_ready,
    output logic [DATA_W-1:0]             rsp_rdata,
    input  logic [NUM_DEV-1:0]            dev_user_mode,
    input  logic [NUM_DEV-1:0]            dev_wr_en,
    output logic                          spi_sck,
    output logic                          spi_mosi,
    input  logic                          spi_miso
);
    localparam int SIZE_W = $clog2(DATA_W / 8);
    localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    typedef struct packed {
        seq_state_e        state;
        logic [SIZE_W-1:0] idx;
        logic [SIZE_W-1:0] last;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             seg_hit;
    logic [DEV_W-1:0] seg_idx;
    logic             sh_start;
    logic [7:0]       sh_tx;
    logic             sh_done;
    logic [7:0]       sh_rx;

    fwsb_seg_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_DEV  (NUM_DEV),
        .SEG0_LOG2(SEG0_LOG2),
        .SEGN_LOG2(SEGN_LOG2)
    ) dec_i (
        .addr    (req_addr),
        .hit     (seg_hit),
        .dev_idx (seg_idx)
    );

    fwsb_spi_shift #(
        .SCK_HALF(SCK_HALF)
    ) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sh_start),
        .tx_byte  (sh_tx),
        .done     (sh_done),
        .rx_byte  (sh_rx),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso)
    );

    always_comb begin
        seq_d    = seq_q;
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (req_valid) begin
                    seq_d.write = req_write;
                    seq_d.wdata = req_wdata;
                    seq_d.last  = req_size;
                    seq_d.idx   = '0;
                    seq_d.rdata = '0;
                    seq_d.state = SEQ_RESP;
                    if (seg_hit) begin
                        if (!dev_user_mode[seg_idx]) begin
                            // not in user mode: reads see all ones, writes drop
                            if (!req_write) begin
                                seq_d.rdata = '1;
                            end
                        end else if (!req_write || dev_wr_en[seg_idx]) begin
                            sh_start    = 1'b1;
                            sh_tx       = req_write ? req_wdata[7:0] : 8'h00;
                            seq_d.state = SEQ_SHIFT;
                        end
                    end
                end
            end
            SEQ_SHIFT: begin
                if (sh_done) begin
                    if (!seq_q.write) begin
                        seq_d.rdata[lane_lsb(32'(seq_q.idx)) +: 8] = sh_rx;
                    end
                    if (seq_q.idx == seq_q.last) begin
                        seq_d.state = SEQ_RESP;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                        sh_start  = 1'b1;
                        sh_tx     = seq_q.write ?
                            seq_q.wdata[lane_lsb(32'(seq_d.idx)) +: 8] : 8'h00;
                    end
                end
            end
            SEQ_RESP: begin
                seq_d.state = SEQ_IDLE;
            end
            default: begin
                seq_d.state = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.state == SEQ_RESP);
    assign rsp_rdata = seq_q.rdata;

endmodule

// File: rtl/fwsb_checker.sv
module fwsb_checker #(
    parameter int NUM_DEV  = 5,
    parameter int DATA_W   = 32,
    parameter int SCK_HALF = 2,
    localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [NUM_DEV-1:0] dev_user_mode,
    input logic [NUM_DEV-1:0] dev_wr_en,
    input logic              spi_sck,
    input logic              spi_mosi,
    input logic              seg_hit,
    input logic [DEV_W-1:0]  seg_idx
);
    logic [15:0] hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else begin
            hi_cnt_q <= spi_sck ? hi_cnt_q + 16'd1 : 16'd0;
        end
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R9
    AST_READY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !spi_sck); // R9
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R10
    AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sck) |-> (hi_cnt_q == 16'(SCK_HALF))); // R10
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_write && !seg_hit) |-> (rsp_rdata == '0)); // R8
    AST_NONUSER_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_write && seg_hit && !dev_user_mode[seg_idx])
        |-> (rsp_rdata == '1)); // R6
    AST_WPROT_NO_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && seg_hit && dev_user_mode[seg_idx]
         && !dev_wr_en[seg_idx]) |-> !spi_sck); // R5
    AST_NONUSER_WRITE_NO_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && seg_hit && !dev_user_mode[seg_idx])
        |-> !spi_sck); // R7

endmodule

bind flash_win_spi_bridge fwsb_checker #(
    .NUM_DEV (NUM_DEV),
    .DATA_W  (DATA_W),
    .SCK_HALF(SCK_HALF)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_ready     (req_ready),
    .rsp_rdata     (rsp_rdata),
    .dev_user_mode (dev_user_mode),
    .dev_wr_en     (dev_wr_en),
    .spi_sck       (spi_sck),
    .spi_mosi      (spi_mosi),
    .seg_hit       (seg_hit),
    .seg_idx       (seg_idx)
);

// File: tb/flash_win_spi_bridge_tb_top.sv
module flash_win_spi_bridge_tb_top;
    localparam int SCK_HALF = 2;
    localparam int NVEC     = 12;

    typedef struct packed {
        logic [3:0]  req;   // requirement number for messages
        logic        wr;
        logic [27:0] addr;
        logic [1:0]  szm1;
        logic [31:0] wd;
        logic [4:0]  user;
        logic [4:0]  wren;
        logic [1:0]  kind;  // read result: 0 zero, 1 all ones, 2 SPI data
        logic [2:0]  nspi;  // expected SPI byte exchanges
    } vec_t;

    // R2 boundary offsets sit in entries 2, 3, 4, 10 and 11
    localparam vec_t VEC [NVEC] = '{
        '{4'd3,  1'b0, 28'h0000010, 2'd3, 32'h00000000, 5'b11111, 5'b00000, 2'd2, 3'd4}, // R3
        '{4'd4,  1'b1, 28'h0000000, 2'd3, 32'hA1B2C3D4, 5'b11111, 5'b11111, 2'd0, 3'd4}, // R4
        '{4'd2,  1'b1, 28'h4000000, 2'd0, 32'h000000E7, 5'b00010, 5'b00010, 2'd0, 3'd1}, // R2
        '{4'd2,  1'b0, 28'hBFFFFFF, 2'd1, 32'h00000000, 5'b10000, 5'b00000, 2'd2, 3'd2}, // R2
        '{4'd11, 1'b0, 28'h3FFFFFF, 2'd2, 32'h00000000, 5'b00001, 5'b00000, 2'd2, 3'd3}, // R11
        '{4'd6,  1'b0, 28'h6000000, 2'd3, 32'h00000000, 5'b11011, 5'b11111, 2'd1, 3'd0}, // R6
        '{4'd7,  1'b1, 28'h8000004, 2'd3, 32'h55AA55AA, 5'b10111, 5'b11111, 2'd0, 3'd0}, // R7
        '{4'd5,  1'b1, 28'h5000000, 2'd1, 32'h0000BEEF, 5'b11111, 5'b11101, 2'd0, 3'd0}, // R5
        '{4'd8,  1'b0, 28'hC000000, 2'd3, 32'h00000000, 5'b11111, 5'b11111, 2'd0, 3'd0}, // R8
        '{4'd8,  1'b1, 28'hFFFFFFC, 2'd3, 32'h12345678, 5'b11111, 5'b11111, 2'd0, 3'd0}, // R8
        '{4'd11, 1'b0, 28'h9FFFFF0, 2'd1, 32'h00000000, 5'b01000, 5'b00000, 2'd2, 3'd2}, // R11
        '{4'd4,  1'b1, 28'h7FFFFFD, 2'd2, 32'h99123456, 5'b00100, 5'b00100, 2'd0, 3'd3}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [27:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic [31:0] rsp_rdata;
    logic [4:0]  dev_user_mode = '0;
    logic [4:0]  dev_wr_en = '0;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_win_spi_bridge #(.SCK_HALF(SCK_HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .dev_user_mode(dev_user_mode), .dev_wr_en(dev_wr_en),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] resp_of(input int n);
        return 8'(32'h5A + n * 19);
    endfunction

    // SPI mode-0 slave model: samples on rise, updates on fall
    int         byte_idx = 0;
    int         rise_total = 0;
    int         rise_cnt = 0;
    logic [2:0] out_idx = '0;
    logic [7:0] rx_sh = '0;
    logic [7:0] mosi_log [256];
    logic [7:0] cur_resp;

    assign cur_resp = resp_of(byte_idx);
    assign spi_miso = cur_resp[~out_idx];

    always @(posedge spi_sck or negedge spi_sck) begin
        if (spi_sck) begin
            rx_sh = {rx_sh[6:0], spi_mosi};
            rise_cnt++;
            rise_total++;
        end else begin
            if (rise_cnt == 8) begin
                mosi_log[byte_idx & 255] = rx_sh;
                byte_idx++;
                rise_cnt = 0;
            end
            out_idx = 3'(rise_cnt);
        end
    end

    // R10 phase monitor
    int   hi_run = 0;
    int   phase_bad = 0;
    int   mosi_bad = 0;
    int   phases = 0;
    logic prev_sck = 1'b0;
    logic prev_mosi = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_sck) begin
                hi_run++;
                if (prev_sck && spi_mosi != prev_mosi) mosi_bad++;
            end else begin
                if (hi_run != 0) begin
                    phases++;
                    if (hi_run != SCK_HALF) phase_bad++;
                end
                hi_run = 0;
            end
            prev_sck  = spi_sck;
            prev_mosi = spi_mosi;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int          start_byte;
        int          start_rise;
        int          cyc;
        int          exp_lat;
        logic [31:0] got;
        logic [31:0] exp;
        string       tag;
        tag        = $sformatf("R%0d", v.req);
        start_byte = byte_idx;
        start_rise = rise_total;
        @(negedge clk);
        req_valid     = 1'b1;
        req_write     = v.wr;
        req_addr      = v.addr;
        req_size      = v.szm1;
        req_wdata     = v.wd;
        dev_user_mode = v.user;
        dev_wr_en     = v.wren;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!req_ready && cyc < 4000);
        got       = rsp_rdata;
        req_valid = 1'b0;
        exp_lat   = 32 * SCK_HALF / 2 * int'(v.nspi) + 1;
        exp_lat   = 16 * SCK_HALF * int'(v.nspi) + 1;
        chk(cyc == exp_lat, "R9 latency", 32'(cyc), 32'(exp_lat));
        chk(!spi_sck, "R9 sck low at ready", {31'b0, spi_sck}, 32'd0);
        if (!v.wr) begin
            exp = '0;
            if (v.kind == 2'd1) exp = '1;
            if (v.kind == 2'd2) begin
                for (int i = 0; i < int'(v.nspi); i++) begin
                    exp = exp | (32'(resp_of(start_byte + i)) << (8 * i));
                end
            end
            chk(got == exp, tag, got, exp);
        end
        chk(rise_total - start_rise == 8 * int'(v.nspi), tag,
            32'(rise_total - start_rise), 32'(8 * int'(v.nspi)));
        for (int i = 0; i < int'(v.nspi); i++) begin
            logic [7:0] want;
            want = v.wr ? v.wd[8 * i +: 8] : 8'h00;
            chk(mosi_log[(start_byte + i) & 255] == want, tag,
                32'(mosi_log[(start_byte + i) & 255]), 32'(want));
        end
        @(negedge clk);
        chk(!req_ready, "R9 single pulse", {31'b0, req_ready}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!req_ready, "R1", {31'b0, req_ready}, 32'd0);
        chk(!spi_sck,   "R1", {31'b0, spi_sck},   32'd0);
        chk(!spi_mosi,  "R1", {31'b0, spi_mosi},  32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_ready && !spi_sck, "R1", {30'b0, req_ready, spi_sck}, 32'd0);

        for (int k = 0; k < NVEC; k++) begin
            run_vec(VEC[k]);
        end

        // R4 chained one-byte writes forming a command, then a data read (R3)
        run_vec('{4'd4, 1'b1, 28'h0000100, 2'd0, 32'h0000009F, 5'b00001, 5'b00001, 2'd0, 3'd1});
        run_vec('{4'd3, 1'b0, 28'h0000100, 2'd0, 32'h00000000, 5'b00001, 5'b00000, 2'd2, 3'd1});
        // R6 flag drop between accesses on the same device
        run_vec('{4'd6, 1'b0, 28'h0000100, 2'd3, 32'h00000000, 5'b11110, 5'b11111, 2'd1, 3'd0});

        // R10 phase and MOSI stability summary
        chk(phases > 0 && phase_bad == 0, "R10 high phase", 32'(phase_bad), 32'd0);
        chk(mosi_bad == 0, "R10 mosi stable", 32'(mosi_bad), 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule